// File: doc/BRIEF.md
# Alternating Two-Bank Frame Buffer with Serial Readout

This block holds zero-suppressed words in two equal memory banks that trade places on every frame boundary. Words of the frame in progress are written into one bank, while the bank holding the completed frame is sent out as a serial bit stream, most significant bit first, one bit per clock. A pulse on `frame_start` closes the frame being written. The closed bank then becomes the readout bank, and the other bank takes new words.

Each frame that goes out is framed by two extra words. A header word carries a running frame number. A trailer word carries the number of words that were kept and a flag that says words were lost. A frame holds at most `DEPTH` words. Any further words in that frame are discarded and an overflow flag is raised. If a new frame boundary arrives while the previous frame is still being sent, the unsent remainder is dropped, an abort pulse is raised, and the new frame's readout begins at once.

Top module: `pp_frame_buffer`

## Requirements
- R1: While `rst_n` is low, and in the cycles after reset until the first `frame_start`, `ser_valid`, `ser_mark`, `ovf_flag` and `rd_abort` are all low.
- R2: The cycle after a `frame_start` clock edge shows the first bit of a header word, with `ser_valid` high. `ser_mark` is high in that cycle only, once per frame.
- R3: The header is a 32-bit word. Its low `FC_W` bits hold the number of earlier `frame_start` pulses since reset (the first readout carries 0), and its upper bits are zero.
- R4: After the header come the stored words of the closed frame, in the order they were written. Every word is sent MSB first, one bit per clock, with no idle cycle between words.
- R5: The trailer follows the last data word. Bit 31 holds the frame's overflow flag, the low bits hold the number of stored words, and all other bits are zero.
- R6: A frame keeps at most `DEPTH` words, and later writes in that frame are discarded. `ovf_flag` goes high in the cycle after the first discarded write. It goes low in the cycle after the next `frame_start`.
- R7: A write presented in the same cycle as `frame_start` belongs to the new frame and becomes that frame's first word.
- R8: A `frame_start` that arrives while a readout still has bits left to send drops those bits. `rd_abort` is then high for one cycle, together with the new header's first bit. A `frame_start` that arrives while no readout is in progress leaves `rd_abort` low.
- R9: Writes made while a readout is running go to the other bank. They do not change the words being sent, and they appear in the next frame's readout.
- R10: After the last trailer bit, `ser_valid` stays low until the next `frame_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. This is also the serial bit clock. |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Frame boundary pulse. Swaps the roles of the two banks. |
| wr_valid | input | 1 | Write strobe for `wr_data` |
| wr_data | input | DATA_W | Zero-suppressed word to store |
| ser_bit | output | 1 | Serial data, MSB first |
| ser_valid | output | 1 | `ser_bit` carries frame content |
| ser_mark | output | 1 | First bit of a header word |
| ovf_flag | output | 1 | The frame being written has discarded words |
| rd_abort | output | 1 | The previous readout was cut short |

## Verification
A `frame_start` sampled at a clock edge makes the header's first bit, `ser_mark` and any `rd_abort` visible right after that same edge. The bench drives each pulse at a falling edge and checks these outputs at the very next falling edge. `ovf_flag` is registered and rises one edge after the first discarded write, so the bench checks it at the falling edge after the seventh write to a bank of six. The bench builds each serial word at falling edges into a queue that the mark clears. It waits until `ser_valid` drops before it compares the queue with the header, data and trailer words it computed itself, and that wait makes the result independent of the frame length.

// File: rtl/pp_fb_pkg.sv
package pp_fb_pkg;
   typedef enum logic [1:0] {
      RD_IDLE,
      RD_HEAD,
      RD_DATA,
      RD_TAIL
   } rd_state_t;
endpackage

// File: rtl/pp_fb_ram.sv
module pp_fb_ram #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 600,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              re,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      if (re) rdata <= mem[raddr];
   end
endmodule

// File: rtl/pp_fb_wrctl.sv
module pp_fb_wrctl #(
   parameter int DEPTH  = 600,
   localparam int AW    = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_start,
   input  logic             wr_valid,
   output logic             wr_bank,
   output logic             wr_sel,
   output logic             wr_en,
   output logic [AW-1:0]    wr_addr,
   output logic [CNT_W-1:0] wr_cnt,
   output logic             ovf
);
   logic room;

   assign room    = wr_cnt < CNT_W'(DEPTH);
   assign wr_en   = wr_valid && (frame_start || room);
   assign wr_sel  = frame_start ? ~wr_bank : wr_bank;
   assign wr_addr = frame_start ? '0 : wr_cnt[AW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_bank <= 1'b0;
         wr_cnt  <= '0;
         ovf     <= 1'b0;
      end else if (frame_start) begin
         wr_bank <= ~wr_bank;
         wr_cnt  <= wr_valid ? CNT_W'(1) : '0;
         ovf     <= 1'b0;
      end else if (wr_valid) begin
         if (room) wr_cnt <= wr_cnt + CNT_W'(1);
         else      ovf    <= 1'b1;
      end
   end
endmodule

// File: rtl/pp_fb_readout.sv
module pp_fb_readout
   import pp_fb_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 600,
   parameter int FC_W   = 16,
   localparam int AW    = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int BW    = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic [CNT_W-1:0]  cur_cnt,
   input  logic              cur_ovf,
   input  logic [DATA_W-1:0] rdata,
   output logic              re,
   output logic [AW-1:0]     raddr,
   output logic              ser_bit,
   output logic              ser_valid,
   output logic              ser_mark,
   output logic              rd_abort
);
   rd_state_t         state;
   logic [BW-1:0]     bitpos;
   logic [DATA_W-1:0] shreg;
   logic [CNT_W-1:0]  idx;
   logic [CNT_W-1:0]  len;
   logic              ovf_l;
   logic [FC_W-1:0]   fcnt;
   logic              last_bit;
   logic              unfinished;
   logic              more;
   logic [DATA_W-1:0] tail_word;

   assign last_bit   = bitpos == BW'(DATA_W - 1);
   assign unfinished = (state != RD_IDLE) && !((state == RD_TAIL) && last_bit);
   assign more       = idx < len;
   assign re         = ((state == RD_HEAD) || (state == RD_DATA)) &&
                       (bitpos == BW'(DATA_W - 2)) && more && !frame_start;
   assign raddr      = idx[AW-1:0];
   assign ser_bit    = shreg[DATA_W-1];
   assign ser_valid  = state != RD_IDLE;

   always_comb begin
      tail_word              = '0;
      tail_word[CNT_W-1:0]   = len;
      tail_word[DATA_W-1]    = ovf_l;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= RD_IDLE;
         bitpos   <= '0;
         shreg    <= '0;
         idx      <= '0;
         len      <= '0;
         ovf_l    <= 1'b0;
         fcnt     <= '0;
         ser_mark <= 1'b0;
         rd_abort <= 1'b0;
      end else if (frame_start) begin
         state    <= RD_HEAD;
         bitpos   <= '0;
         shreg    <= DATA_W'(fcnt);
         fcnt     <= fcnt + FC_W'(1);
         len      <= cur_cnt;
         ovf_l    <= cur_ovf;
         idx      <= '0;
         ser_mark <= 1'b1;
         rd_abort <= unfinished;
      end else begin
         ser_mark <= 1'b0;
         rd_abort <= 1'b0;
         if (state != RD_IDLE) begin
            if (!last_bit) begin
               bitpos <= bitpos + BW'(1);
               shreg  <= {shreg[DATA_W-2:0], 1'b0};
            end else begin
               bitpos <= '0;
               case (state)
                  RD_HEAD, RD_DATA: begin
                     if (more) begin
                        shreg <= rdata;
                        idx   <= idx + CNT_W'(1);
                        state <= RD_DATA;
                     end else begin
                        shreg <= tail_word;
                        state <= RD_TAIL;
                     end
                  end
                  default: begin
                     shreg <= '0;
                     state <= RD_IDLE;
                  end
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/pp_frame_buffer.sv
module pp_frame_buffer #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 600,
   parameter int FC_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   output logic              ser_bit,
   output logic              ser_valid,
   output logic              ser_mark,
   output logic              ovf_flag,
   output logic              rd_abort
);
   localparam int AW    = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("pp_frame_buffer: DEPTH must be at least 2");
   end
   if (DATA_W < 8) begin : g_bad_width
      $error("pp_frame_buffer: DATA_W must be at least 8");
   end
   if (DATA_W < CNT_W + 1) begin : g_bad_trailer
      $error("pp_frame_buffer: trailer cannot hold count and flag");
   end
   if (FC_W > DATA_W || FC_W < 1) begin : g_bad_fc
      $error("pp_frame_buffer: FC_W out of range");
   end

   logic              wr_bank;
   logic              wr_sel;
   logic              wr_en;
   logic [AW-1:0]     wr_addr;
   logic [CNT_W-1:0]  wr_cnt;
   logic              rd_re;
   logic [AW-1:0]     rd_addr;
   logic [DATA_W-1:0] bank_rd [2];
   logic [DATA_W-1:0] rd_word;

   pp_fb_wrctl #(.DEPTH(DEPTH)) u_wrctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .wr_valid    (wr_valid),
      .wr_bank     (wr_bank),
      .wr_sel      (wr_sel),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_cnt      (wr_cnt),
      .ovf         (ovf_flag)
   );

   for (genvar b = 0; b < 2; b++) begin : g_bank
      pp_fb_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
         .clk   (clk),
         .we    (wr_en && (wr_sel == 1'(b))),
         .waddr (wr_addr),
         .wdata (wr_data),
         .re    (rd_re && (~wr_bank == 1'(b))),
         .raddr (rd_addr),
         .rdata (bank_rd[b])
      );
   end

   assign rd_word = bank_rd[~wr_bank];

   pp_fb_readout #(.DATA_W(DATA_W), .DEPTH(DEPTH), .FC_W(FC_W)) u_readout (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .cur_cnt     (wr_cnt),
      .cur_ovf     (ovf_flag),
      .rdata       (rd_word),
      .re          (rd_re),
      .raddr       (rd_addr),
      .ser_bit     (ser_bit),
      .ser_valid   (ser_valid),
      .ser_mark    (ser_mark),
      .rd_abort    (rd_abort)
   );
endmodule

// File: rtl/pp_frame_buffer_chk.sv
module pp_frame_buffer_chk (
   input logic clk,
   input logic rst_n,
   input logic frame_start,
   input logic wr_valid,
   input logic ser_valid,
   input logic ser_mark,
   input logic ovf_flag,
   input logic rd_abort
);
   assert_mark_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ser_mark |-> ser_valid);

   assert_start_readout_R2: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> (ser_mark && ser_valid));

   assert_ovf_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> !ovf_flag);

   assert_ovf_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> $past(wr_valid));

   assert_abort_mark_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_abort |-> ser_mark);

   assert_abort_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_abort |-> $past(ser_valid));
endmodule

bind pp_frame_buffer pp_frame_buffer_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .frame_start (frame_start),
   .wr_valid    (wr_valid),
   .ser_valid   (ser_valid),
   .ser_mark    (ser_mark),
   .ovf_flag    (ovf_flag),
   .rd_abort    (rd_abort)
);

// File: tb/pp_frame_buffer_bench.sv
module pp_frame_buffer_bench;
   localparam int DW  = 32;
   localparam int DEP = 6;
   localparam int FCW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          frame_start = 1'b0;
   logic          wr_valid = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          ser_bit, ser_valid, ser_mark, ovf_flag, rd_abort;

   int nchk = 0;
   int nerr = 0;
   bit done = 0;
   int swaps = 0;
   bit pend_ovf = 0;
   logic [DW-1:0] pend[$];
   logic [DW-1:0] expq[$];
   logic [DW-1:0] rx[$];
   logic [DW-1:0] cur = '0;
   int bitn = 0;

   always #4 clk = ~clk;

   pp_frame_buffer #(.DATA_W(DW), .DEPTH(DEP), .FC_W(FCW)) u_pp_frame_buffer (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .wr_valid(wr_valid),
      .wr_data(wr_data), .ser_bit(ser_bit), .ser_valid(ser_valid),
      .ser_mark(ser_mark), .ovf_flag(ovf_flag), .rd_abort(rd_abort)
   );

   always @(negedge clk) begin
      if (rst_n && ser_valid) begin
         if (ser_mark) begin
            rx.delete();
            bitn = 0;
         end
         cur = {cur[DW-2:0], ser_bit};
         bitn++;
         if (bitn == DW) begin
            rx.push_back(cur);
            bitn = 0;
         end
      end
   end

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // all tasks start and end just after a falling edge
   task automatic wr(input logic [DW-1:0] d);
      wr_valid = 1'b1;
      wr_data  = d;
      if (pend.size() < DEP) pend.push_back(d);
      else pend_ovf = 1;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic swap(input bit with_wr, input logic [DW-1:0] d, input bit exp_abort);
      logic [DW-1:0] tw;
      expq.delete();
      expq.push_back(DW'(swaps[FCW-1:0]));
      foreach (pend[i]) expq.push_back(pend[i]);
      tw = DW'(pend.size());
      tw[DW-1] = pend_ovf;
      expq.push_back(tw);
      swaps++;
      pend.delete();
      pend_ovf = 0;
      frame_start = 1'b1;
      wr_valid = with_wr;
      wr_data = d;
      if (with_wr) pend.push_back(d);
      @(negedge clk);
      frame_start = 1'b0;
      wr_valid = 1'b0;
      chk("R2 mark", {31'd0, ser_mark}, 32'd1);
      chk("R2 valid", {31'd0, ser_valid}, 32'd1);
      chk("R6 ovf cleared", {31'd0, ovf_flag}, 32'd0);
      chk("R8 abort", {31'd0, rd_abort}, {31'd0, exp_abort});
   endtask

   task automatic drain(input string tag);
      for (int k = 0; k < 4000 && ser_valid; k++) @(negedge clk);
      chk({tag, " R4 word count"}, DW'(rx.size()), DW'(expq.size()));
      foreach (expq[i]) begin
         if (i < rx.size()) begin
            if (i == 0) chk({tag, " R3 header"}, rx[i], expq[i]);
            else if (i == expq.size() - 1) chk({tag, " R5 trailer"}, rx[i], expq[i]);
            else chk({tag, " R4 data"}, rx[i], expq[i]);
         end
      end
      repeat (5) @(negedge clk);
      chk({tag, " R10 idle"}, {31'd0, ser_valid}, 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 valid", {31'd0, ser_valid}, 32'd0);
      chk("R1 mark", {31'd0, ser_mark}, 32'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 ovf", {31'd0, ovf_flag}, 32'd0);
      chk("R1 abort", {31'd0, rd_abort}, 32'd0);
      chk("R1 idle", {31'd0, ser_valid}, 32'd0);

      // sweep of frame sizes, including empty, full and beyond capacity
      for (int n = 0; n <= DEP + 2; n++) begin
         for (int i = 0; i < n; i++) begin
            wr(32'hC000_0000 ^ (n << 16) ^ (i * 32'h0101_0357));
            if (i == DEP - 1) chk("R6 ovf at capacity", {31'd0, ovf_flag}, 32'd0);
            if (i == DEP) chk("R6 ovf after drop", {31'd0, ovf_flag}, 32'd1);
         end
         swap(0, '0, 0);
         drain("sweep");
      end

      // R7: write coincident with the boundary opens the new frame
      wr(32'h1111_2222);
      wr(32'h3333_4444);
      swap(1, 32'hDEAD_BEEF, 0);
      drain("R7a");
      swap(0, '0, 0);
      drain("R7 first word");

      // R9: writes during readout land in the other bank
      for (int i = 0; i < 4; i++) wr(32'hA000_0000 + i);
      swap(0, '0, 0);
      repeat (20) @(negedge clk);
      for (int i = 0; i < 3; i++) wr(32'h5000_0F00 + i);
      drain("R9 current");
      swap(0, '0, 0);
      drain("R9 next");

      // R8: boundary during readout abandons the rest
      for (int i = 0; i < 5; i++) wr(32'h7700_0000 + i);
      swap(0, '0, 0);
      repeat (50) @(negedge clk);
      wr(32'h0BAD_F00D);
      wr(32'h00C0_FFEE);
      swap(0, '0, 1);
      drain("R8 after abort");

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         nerr++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end
endmodule